// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Sequencer

This block is the card-side control logic of a legacy plug-and-play expansion card. It follows the card through four configuration states (waiting for the initiation key, sleeping, isolating and configuring). The host reaches it through two write ports and one read strobe. The first write port loads an index. The second writes data to the register that the index selects. The read strobe returns the selected register's value on the following cycle.

The block holds the card select number, the selected logical device number and the relocatable host read-port address. It also carries out three commands: wake, card select number assignment and global control. Global control commands act as self-clearing strobes. A small resource-byte reader stands in for the card's resource memory. It produces a computed byte stream behind a ready flag, and that flag drops for a fixed number of cycles after each byte is taken.

The following are outside the block and reach it only as plain signals: the key detector, the serial-identification comparison and the per-device resource registers. One example is the one-cycle `dev_reset_o` strobe that the device register file acts on. All host accesses are single-cycle strobes that the block always accepts, so there is no back-pressure. A read always completes with `rd_vld_o` exactly one cycle after `rd_stb_i`.

Top module: `pnp_cfg_seq`

## Requirements
- R1: After reset the card is waiting for the key: `state_o` = 0, and the card select number, logical device number and read-port bits are all 0. The ready flag is set, `rd_vld_o` = 0 and `dev_reset_o` = 0. The `state_o` encoding is 0 = key wait, 1 = sleep, 2 = isolation, 3 = config.
- R2: A `key_seen_i` pulse moves the card from key wait to sleep on the next clock. In any other state the pulse is ignored.
- R3: A data write to index 0x03 (wake) while the card sleeps compares the data with the card select number. If they match, the card goes to isolation when the data is 0 and to config otherwise. A mismatch leaves the card asleep, and a wake while waiting for the key has no effect.
- R4: Every wake write accepted outside key wait rewinds the resource byte pointer to the first byte, whatever the state and whether or not the data matched.
- R5: A data write to index 0x06 sets the card select number in isolation or config, and a write in isolation also moves the card to config. A read of index 0x06 in config returns the number.
- R6: A data write to index 0x02 outside key wait acts on three bits. Bit 2 clears the card select number. Bit 1 returns the card to key wait and keeps the number and device selection. Bit 0 raises `dev_reset_o` for exactly one cycle and keeps the number. The bits are strobes that leave no stored state.
- R7: A data write of V to index 0x00 in config sets `rd_port_addr_o` to {V, 2'b11}. A read of index 0x00 returns 0x00.
- R8: A data write to index 0x07 in config selects logical device V when V < NUM_LDN and is ignored otherwise. A read of index 0x07 returns the selection, and a single-device build always reads 0.
- R9: Writes to indexes 0x00, 0x06 and 0x07 are ignored outside config, except that 0x06 is also accepted in isolation.
- R10: `rd_vld_o` rises one cycle after `rd_stb_i`. Every read outside config returns 0x00.
- R11: A read of index 0x05 returns the ready flag in bit 0. A read of index 0x04 when ready returns byte k = (RES_SEED + k*RES_MUL) mod 256 and advances k. After that read the ready flag stays low for FETCH_CYC cycles.
- R12: A read of index 0x04 while the ready flag is low returns 0x00 and leaves the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_seen_i | input | 1 | One-cycle pulse from the external key detector |
| idx_wr_i | input | 1 | Index write strobe |
| idx_i | input | 8 | Index value |
| dat_wr_i | input | 1 | Data write strobe to the indexed register |
| dat_i | input | 8 | Write data |
| rd_stb_i | input | 1 | Read strobe of the indexed register |
| rd_data_o | output | 8 | Read result, valid with rd_vld_o |
| rd_vld_o | output | 1 | Read result valid, one cycle after rd_stb_i |
| state_o | output | 2 | Configuration state (0 key wait, 1 sleep, 2 isolation, 3 config) |
| csn_o | output | 8 | Card select number |
| ldn_o | output | LDN_W | Selected logical device |
| rd_port_addr_o | output | 10 | Host read-port address |
| dev_reset_o | output | 1 | One-cycle logical-device reset strobe |

## Verification
The wake command is driven with three kinds of data: zero on a matching number, non-zero on a matching number, and a mismatching value. These separate the isolation and config targets from no movement at all. Each control bit is written on its own so that the bench can see which stored values each bit touches and which it preserves. Resource reads are issued with generous spacing to confirm the byte sequence and the pointer rewind. They are then issued back to back with status reads, which confirms that a read made while busy neither returns data nor advances the pointer. Writes to config-only indexes are repeated while the card sleeps, and the ports show that nothing changed.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  typedef enum logic [1:0] {
    ST_WFK   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ISO   = 2'd2,
    ST_CFG   = 2'd3
  } pnp_state_e;

  localparam logic [7:0] IX_RDPORT = 8'h00;
  localparam logic [7:0] IX_ISOL   = 8'h01;
  localparam logic [7:0] IX_CTRL   = 8'h02;
  localparam logic [7:0] IX_WAKE   = 8'h03;
  localparam logic [7:0] IX_RES    = 8'h04;
  localparam logic [7:0] IX_STAT   = 8'h05;
  localparam logic [7:0] IX_CSN    = 8'h06;
  localparam logic [7:0] IX_LDN    = 8'h07;

  localparam int CTL_DEVRST = 0;
  localparam int CTL_WFK    = 1;
  localparam int CTL_CSNCLR = 2;

endpackage

// File: rtl/pnp_fsm.sv
module pnp_fsm
  import pnp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_seen_i,
  input  logic       wake_stb_i,
  input  logic [7:0] wake_dat_i,
  input  logic [7:0] csn_i,
  input  logic       csn_wr_i,
  input  logic       ctl_wfk_i,
  output pnp_state_e state_o
);

  pnp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctl_wfk_i) begin
      state_d = ST_WFK;
    end else begin
      unique case (state_q)
        ST_WFK:   if (key_seen_i) state_d = ST_SLEEP;
        ST_SLEEP: if (wake_stb_i && wake_dat_i == csn_i)
                    state_d = (wake_dat_i == 8'h00) ? ST_ISO : ST_CFG;
        ST_ISO:   if (csn_wr_i) state_d = ST_CFG;
        ST_CFG:   state_d = ST_CFG;
        default:  state_d = ST_WFK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WFK;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  AST_KEY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WFK && key_seen_i && !ctl_wfk_i) |=> state_q == ST_SLEEP); // R2
  AST_KEY_ONLY_WFK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CFG && !ctl_wfk_i) |=> state_q == ST_CFG); // R2
  AST_CTL_TO_WFK: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wfk_i |=> state_q == ST_WFK); // R6
  AST_ISO_CSN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISO && csn_wr_i && !ctl_wfk_i) |=> state_q == ST_CFG); // R5
  AST_WAKE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wake_stb_i && wake_dat_i != csn_i) |=> state_q == ST_SLEEP); // R3

endmodule

// File: rtl/pnp_card_regs.sv
module pnp_card_regs
  import pnp_pkg::*;
#(
  parameter int NUM_LDN = 2,
  localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr_i,
  input  logic [7:0]       idx_i,
  input  logic             dat_wr_i,
  input  logic [7:0]       dat_i,
  input  pnp_state_e       state_i,
  output logic [7:0]       idx_o,
  output logic [7:0]       csn_o,
  output logic [LDN_W-1:0] ldn_o,
  output logic [7:0]       rdport_o,
  output logic             wake_stb_o,
  output logic             csn_wr_o,
  output logic             ctl_wfk_o,
  output logic             dev_rst_o
);

  logic [7:0] idx_q, csn_q, rdport_q;
  logic       dev_rst_q;
  logic       live, in_cfg, ctrl_acc, rdport_acc, ldn_acc;

  assign live       = dat_wr_i && (state_i != ST_WFK);
  assign in_cfg     = dat_wr_i && (state_i == ST_CFG);
  assign ctrl_acc   = live && (idx_q == IX_CTRL);
  assign wake_stb_o = live && (idx_q == IX_WAKE);
  assign csn_wr_o   = dat_wr_i && (idx_q == IX_CSN) &&
                      (state_i == ST_ISO || state_i == ST_CFG);
  assign rdport_acc = in_cfg && (idx_q == IX_RDPORT);
  assign ldn_acc    = in_cfg && (idx_q == IX_LDN);
  assign ctl_wfk_o  = ctrl_acc && dat_i[CTL_WFK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= IX_RDPORT;
    else if (idx_wr_i) idx_q <= idx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q <= 8'h00;
    end else if (ctrl_acc && dat_i[CTL_CSNCLR]) begin
      csn_q <= 8'h00;
    end else if (csn_wr_o) begin
      csn_q <= dat_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdport_q <= 8'h00;
    else if (rdport_acc) rdport_q <= dat_i;
  end

  // strobe: set for the cycle after the write, cleared by hardware
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_rst_q <= 1'b0;
    else        dev_rst_q <= ctrl_acc && dat_i[CTL_DEVRST];
  end

  generate
    if (NUM_LDN > 1) begin : g_multi
      logic [LDN_W-1:0] ldn_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldn_q <= '0;
        else if (ldn_acc && (32'(dat_i) < NUM_LDN)) ldn_q <= dat_i[LDN_W-1:0];
      end
      assign ldn_o = ldn_q;
      AST_LDN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ldn_q) < NUM_LDN); // R8
    end else begin : g_single
      assign ldn_o = '0;
    end
  endgenerate

  assign idx_o    = idx_q;
  assign csn_o    = csn_q;
  assign rdport_o = rdport_q;
  assign dev_rst_o = dev_rst_q;

  AST_CSN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_acc && dat_i[CTL_CSNCLR]) |=> csn_q == 8'h00); // R6
  AST_DEVRST_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_q |-> $past(dat_wr_i && idx_q == IX_CTRL)); // R6
  AST_CSN_HOLD_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_SLEEP && !ctrl_acc) |=> $stable(csn_q)); // R9
  AST_RDPORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_CFG) |=> $stable(rdport_q)); // R9

endmodule

// File: rtl/pnp_res_reader.sv
module pnp_res_reader #(
  parameter int         PTR_W     = 8,
  parameter int         FETCH_CYC = 4,
  parameter logic [7:0] RES_SEED  = 8'h5A,
  parameter logic [7:0] RES_MUL   = 8'd29,
  localparam int        CNT_W     = $clog2(FETCH_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rewind_i,
  input  logic       pull_i,
  output logic       ready_o,
  output logic [7:0] byte_o
);

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] busy_q;
  logic             adv;

  assign ready_o = (busy_q == '0);
  assign adv     = pull_i && ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (rewind_i) ptr_q <= '0;
    else if (adv)      ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_q <= '0;
    else if (adv)         busy_q <= CNT_W'(FETCH_CYC);
    else if (!ready_o)    busy_q <= busy_q - 1'b1;
  end

  assign byte_o = RES_SEED + 8'(ptr_q) * RES_MUL;

  AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_i |=> ptr_q == '0); // R4
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !ready_o); // R11
  AST_BUSY_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !rewind_i) |=> $stable(ptr_q)); // R12

endmodule

// File: rtl/pnp_cfg_seq.sv
module pnp_cfg_seq
  import pnp_pkg::*;
#(
  parameter int         NUM_LDN   = 2,
  parameter int         FETCH_CYC = 4,
  parameter int         PTR_W     = 8,
  parameter logic [7:0] RES_SEED  = 8'h5A,
  parameter logic [7:0] RES_MUL   = 8'd29,
  localparam int        LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_seen_i,
  input  logic             idx_wr_i,
  input  logic [7:0]       idx_i,
  input  logic             dat_wr_i,
  input  logic [7:0]       dat_i,
  input  logic             rd_stb_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_vld_o,
  output logic [1:0]       state_o,
  output logic [7:0]       csn_o,
  output logic [LDN_W-1:0] ldn_o,
  output logic [9:0]       rd_port_addr_o,
  output logic             dev_reset_o
);

  pnp_state_e       state;
  logic [7:0]       idx, csn, rdport, res_byte;
  logic [LDN_W-1:0] ldn;
  logic             wake_stb, csn_wr, ctl_wfk, res_ready, res_pull;
  logic [7:0]       rd_mux;
  logic [7:0]       rd_data_q;
  logic             rd_vld_q;

  pnp_card_regs #(.NUM_LDN(NUM_LDN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr_i   (idx_wr_i),
    .idx_i      (idx_i),
    .dat_wr_i   (dat_wr_i),
    .dat_i      (dat_i),
    .state_i    (state),
    .idx_o      (idx),
    .csn_o      (csn),
    .ldn_o      (ldn),
    .rdport_o   (rdport),
    .wake_stb_o (wake_stb),
    .csn_wr_o   (csn_wr),
    .ctl_wfk_o  (ctl_wfk),
    .dev_rst_o  (dev_reset_o)
  );

  pnp_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_seen_i (key_seen_i),
    .wake_stb_i (wake_stb),
    .wake_dat_i (dat_i),
    .csn_i      (csn),
    .csn_wr_i   (csn_wr),
    .ctl_wfk_i  (ctl_wfk),
    .state_o    (state)
  );

  assign res_pull = rd_stb_i && (state == ST_CFG) && (idx == IX_RES);

  pnp_res_reader #(
    .PTR_W     (PTR_W),
    .FETCH_CYC (FETCH_CYC),
    .RES_SEED  (RES_SEED),
    .RES_MUL   (RES_MUL)
  ) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .rewind_i (wake_stb),
    .pull_i   (res_pull),
    .ready_o  (res_ready),
    .byte_o   (res_byte)
  );

  always_comb begin
    rd_mux = 8'h00;
    if (state == ST_CFG) begin
      unique case (idx)
        IX_STAT: rd_mux = {7'd0, res_ready};
        IX_RES:  rd_mux = res_ready ? res_byte : 8'h00;
        IX_CSN:  rd_mux = csn;
        IX_LDN:  rd_mux = 8'(ldn);
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= 8'h00;
      rd_vld_q  <= 1'b0;
    end else begin
      rd_vld_q <= rd_stb_i;
      if (rd_stb_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_data_o      = rd_data_q;
  assign rd_vld_o       = rd_vld_q;
  assign state_o        = state;
  assign csn_o          = csn;
  assign ldn_o          = ldn;
  assign rd_port_addr_o = {rdport, 2'b11};

  AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_vld_o); // R10
  AST_RD_OUTSIDE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && state != ST_CFG) |=> rd_data_o == 8'h00); // R10
  AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && idx == IX_RES && !res_ready) |=> rd_data_o == 8'h00); // R12

endmodule

// File: tb/tb_pnp_cfg_seq.sv
module tb_pnp_cfg_seq;

  localparam int         NUM_LDN   = 2;
  localparam int         FETCH_CYC = 4;
  localparam logic [7:0] SEED      = 8'h5A;
  localparam logic [7:0] MUL       = 8'd29;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_seen = 1'b0, idx_wr = 1'b0, dat_wr = 1'b0, rd_stb = 1'b0;
  logic [7:0] idx_v = 8'h00, dat_v = 8'h00;
  logic [7:0] rd_data, csn;
  logic       rd_vld, dev_reset;
  logic [1:0] state;
  logic [0:0] ldn;
  logic [9:0] rp_addr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pnp_cfg_seq #(
    .NUM_LDN(NUM_LDN), .FETCH_CYC(FETCH_CYC), .PTR_W(8),
    .RES_SEED(SEED), .RES_MUL(MUL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .key_seen_i(key_seen),
    .idx_wr_i(idx_wr), .idx_i(idx_v), .dat_wr_i(dat_wr), .dat_i(dat_v),
    .rd_stb_i(rd_stb), .rd_data_o(rd_data), .rd_vld_o(rd_vld),
    .state_o(state), .csn_o(csn), .ldn_o(ldn),
    .rd_port_addr_o(rp_addr), .dev_reset_o(dev_reset)
  );

  function automatic logic [7:0] ref_res(input int k);
    return 8'(int'(SEED) + k * int'(MUL));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    idx_wr = 1'b1; idx_v = i;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    set_idx(i);
    dat_wr = 1'b1; dat_v = d;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] v, output logic vl);
    set_idx(i);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data; vl = rd_vld;
  endtask

  task automatic key_pulse();
    key_seen = 1'b1;
    @(negedge clk);
    key_seen = 1'b0;
  endtask

  // op(2) idx(8) dat(8) exp(9: bit8 => resource byte number) req(4)
  localparam int NV = 13;
  localparam logic [30:0] VEC [NV] = '{
    {2'd1, 8'h06, 8'h00, 9'h005, 4'd5},   // R5 csn readback
    {2'd0, 8'h00, 8'h3C, 9'h000, 4'd7},   // R7 read port write
    {2'd1, 8'h00, 8'h00, 9'h000, 4'd7},   // R7 read port reads zero
    {2'd1, 8'h05, 8'h00, 9'h001, 4'd11},  // R11 status ready
    {2'd1, 8'h04, 8'h00, 9'h100, 4'd11},  // R11 byte 0
    {2'd1, 8'h04, 8'h00, 9'h101, 4'd11},  // R11 byte 1
    {2'd1, 8'h04, 8'h00, 9'h102, 4'd11},  // R11 byte 2
    {2'd0, 8'h03, 8'h00, 9'h000, 4'd4},   // R4 wake rewinds
    {2'd1, 8'h04, 8'h00, 9'h100, 4'd4},   // R4 byte 0 again
    {2'd0, 8'h07, 8'h01, 9'h000, 4'd8},   // R8 select device 1
    {2'd1, 8'h07, 8'h00, 9'h001, 4'd8},   // R8
    {2'd0, 8'h07, 8'h05, 9'h000, 4'd8},   // R8 out of range ignored
    {2'd1, 8'h07, 8'h00, 9'h001, 4'd8}    // R8
  };

  initial begin
    logic [7:0] v;
    logic       vl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 state", state, 0);
    check("R1 csn", csn, 0);
    check("R1 ldn", ldn, 0);
    check("R1 rd_port", rp_addr, 10'h003);
    check("R1 rd_vld", rd_vld, 0);
    check("R1 dev_reset", dev_reset, 0);

    // R3 wake ignored in key wait
    wr(8'h03, 8'h00);
    check("R3 wake in key wait", state, 0);
    // R2 key moves to sleep
    key_pulse();
    check("R2 key to sleep", state, 1);
    // R3 mismatched wake leaves asleep
    wr(8'h03, 8'h07);
    check("R3 wake mismatch", state, 1);
    // R3 zero wake matching csn 0 -> isolation
    wr(8'h03, 8'h00);
    check("R3 wake zero to iso", state, 2);
    // R10 read outside config
    rd(8'h06, v, vl);
    check("R10 rd_vld", vl, 1);
    check("R10 data outside cfg", v, 0);
    // R5 csn in isolation -> config
    wr(8'h06, 8'h05);
    check("R5 iso to cfg", state, 3);
    check("R5 csn value", csn, 5);

    // vector table
    for (int n = 0; n < NV; n++) begin
      logic [1:0] op;
      logic [7:0] ix, dt;
      logic [8:0] ex;
      int rq, expv;
      op = VEC[n][30:29]; ix = VEC[n][28:21]; dt = VEC[n][20:13];
      ex = VEC[n][12:4];  rq = int'(VEC[n][3:0]);
      if (op == 2'd0) begin
        wr(ix, dt);
      end else begin
        rd(ix, v, vl);
        expv = ex[8] ? int'(ref_res(int'(ex[7:0]))) : int'(ex[7:0]);
        check($sformatf("R%0d vector %0d", rq, n), v, expv);
      end
      repeat (6) @(negedge clk);
    end

    // R7 address output
    check("R7 rd_port_addr", rp_addr, 10'h0F3);

    // R11 / R12 busy window; pointer is at 1
    rd(8'h04, v, vl);
    check("R11 byte 1", v, ref_res(1));
    rd(8'h05, v, vl);
    check("R11 status busy", v, 0);
    rd(8'h04, v, vl);
    check("R12 busy read zero", v, 0);
    repeat (4) @(negedge clk);
    rd(8'h04, v, vl);
    check("R12 pointer held", v, ref_res(2));
    repeat (6) @(negedge clk);

    // R6 bit 0
    wr(8'h02, 8'h01);
    check("R6 dev_reset pulse", dev_reset, 1);
    check("R6 csn kept bit0", csn, 5);
    @(negedge clk);
    check("R6 dev_reset clears", dev_reset, 0);
    // R6 bit 1
    wr(8'h02, 8'h02);
    check("R6 back to key wait", state, 0);
    check("R6 csn kept bit1", csn, 5);
    check("R6 ldn kept bit1", ldn, 1);
    key_pulse();
    // R9 writes ignored while asleep
    wr(8'h06, 8'h09);
    check("R9 csn write in sleep", csn, 5);
    wr(8'h00, 8'h11);
    check("R9 rd_port in sleep", rp_addr, 10'h0F3);
    // R3 nonzero matching wake -> config
    wr(8'h03, 8'h05);
    check("R3 wake nonzero to cfg", state, 3);
    // R2 key ignored outside key wait
    key_pulse();
    check("R2 key ignored", state, 3);
    // R6 bit 2
    wr(8'h02, 8'h04);
    check("R6 csn cleared", csn, 0);
    check("R6 state kept bit2", state, 3);
    rd(8'h06, v, vl);
    check("R5 csn read after clear", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule